// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Edge Capture

This block is a general-purpose I/O port of configurable width (32 bits by default) that sits on a simple single-cycle register bus. Software writes an output register and a per-bit output-enable register, and reads the pin levels through a two-stage synchroniser. Two write-only registers let software set or clear individual output bits atomically, with no read-modify-write.

Every synchronised input feeds an edge detector. The detector compares the synchronised value with its value one cycle earlier and looks for rising, falling or both kinds of edge, as chosen by a parameter. Detected edges set sticky bits in a capture register. A build-time parameter decides how software clears the capture register: either any write clears the whole register, or each written 1 clears only its own bit. A mask register selects which captured bits drive the single level interrupt output.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the output register, the output-enable (direction) register, the interrupt mask and the capture register are all zero, so `pin_oe`, `pin_out` and `irq` are 0.
- R2: Word addresses are 0 data, 1 direction, 2 interrupt mask, 3 capture, 4 set, 5 clear. A write to address 0 loads the output register. A read of address 0 returns `pin_in` as sampled through two flops, so a pin change made before clock edge k is readable after edge k+1.
- R3: `pin_oe` equals the direction register, which reads back at address 1. Each bit of `pin_out` equals the output register bit where its direction bit is 1 and is 0 where it is 0.
- R4: A write to address 4 ORs `bus_wdata` into the output register, and a write to address 5 clears the output bits where `bus_wdata` is 1. Both addresses read as zero.
- R5: Parameter `EDGE_KIND` selects rising (EDGE_RISE), falling (EDGE_FALL) or both (EDGE_ANY). A pin change made before edge k that matches the selected kind sets its capture bit at edge k+2.
- R6: Capture bits stay set until cleared. When `W1C` is 1, a write to address 3 clears only the bits written as 1. When `W1C` is 0, any write to address 3 clears every bit.
- R7: If an edge is detected on a bit in the same cycle that a write clears that bit, the bit remains set.
- R8: `irq` is high exactly when some bit is set in both the capture register and the interrupt mask (address 2).
- R9: `bus_rdata` is zero while `bus_rd` is low and for addresses 6 and 7. Writes to addresses 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word address of the register |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wr | input | 1 | Write strobe; takes effect at the next clock edge |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Output values, gated by direction |
| pin_oe | output | WIDTH | Per-bit output enable for the pad buffers |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong capture bit shows at `irq` one cycle after the faulty edge when that bit is masked in, and at a capture read at any later time, because the bit is sticky. A synchroniser that is one stage short or long shows as data reads and capture updates one cycle out of step with the expected pipeline. A bad set, clear or direction path shows on `pin_out` the cycle after the write. The bench therefore compares every port on every cycle, with three builds that cover the three edge kinds and both clearing styles.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_ANY  = 2'd2
  } edge_kind_e;

  localparam int ADDR_W = 3;

  // word addresses; software sees these times four
  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAPT = 3'd3;
  localparam logic [ADDR_W-1:0] A_SET  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd5;

  localparam int MAXW = 64;

  // edges between previous and current synchronised sample
  function automatic logic [MAXW-1:0] edge_bits(
    input logic [MAXW-1:0] cur,
    input logic [MAXW-1:0] prev,
    input edge_kind_e      kind
  );
    logic [MAXW-1:0] up, dn;
    up = cur & ~prev;
    dn = ~cur & prev;
    case (kind)
      EDGE_RISE: edge_bits = up;
      EDGE_FALL: edge_bits = dn;
      default:   edge_bits = up | dn;
    endcase
  endfunction

  // bits of the capture register a write removes
  function automatic logic [MAXW-1:0] capture_clear(
    input logic [MAXW-1:0] wdata,
    input logic            per_bit
  );
    capture_clear = per_bit ? wdata : {MAXW{1'b1}};
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end

endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_edge_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  mask_q
);

  logic set_hit, clr_hit, data_hit;
  assign data_hit = wr && (addr == A_DATA);
  assign set_hit  = wr && (addr == A_SET);
  assign clr_hit  = wr && (addr == A_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else begin
      if (data_hit)     out_q <= wdata;
      else if (set_hit) out_q <= out_q | wdata;
      else if (clr_hit) out_q <= out_q & ~wdata;
      if (wr && addr == A_DIR)  dir_q  <= wdata;
      if (wr && addr == A_MASK) mask_q <= wdata;
    end
  end

  // R4
  set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((out_q & $past(wdata)) == $past(wdata)));

  // R4
  clr_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((out_q & $past(wdata)) == '0));

  // R4
  set_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((out_q & $past(out_q)) == $past(out_q)));

  // R9
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr > A_CLR) |=> ($stable(out_q) && $stable(dir_q) && $stable(mask_q)));

endmodule

// File: rtl/gpio_edge_cap.sv
module gpio_edge_cap
  import gpio_edge_pkg::*;
#(
  parameter int         WIDTH     = 32,
  parameter edge_kind_e EDGE_KIND = EDGE_RISE,
  parameter bit         W1C       = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_in,
  input  logic             clr_wr,
  input  logic [WIDTH-1:0] clr_data,
  output logic [WIDTH-1:0] edge_hit,
  output logic [WIDTH-1:0] cap_q
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] clr_mask;
  logic [MAXW-1:0]  edge_wide, clr_wide;

  always_comb begin
    edge_wide = edge_bits(MAXW'(sync_in), MAXW'(prev_q), EDGE_KIND);
    clr_wide  = capture_clear(MAXW'(clr_data), W1C);
  end

  assign edge_hit = edge_wide[WIDTH-1:0];
  assign clr_mask = clr_wr ? clr_wide[WIDTH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      cap_q  <= '0;
    end else begin
      prev_q <= sync_in;
      cap_q  <= (cap_q & ~clr_mask) | edge_hit;
    end
  end

  // R5
  edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit & ~(sync_in ^ prev_q)) == '0);

  // R6
  cap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((cap_q & $past(cap_q & ~clr_mask)) == $past(cap_q & ~clr_mask)));

  // R7
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((cap_q & $past(edge_hit)) == $past(edge_hit)));

  // R6
  cap_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((cap_q & ~$past(cap_q) & ~$past(edge_hit)) == '0));

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int         WIDTH     = 32,
  parameter edge_kind_e EDGE_KIND = EDGE_RISE,
  parameter bit         W1C       = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic              irq
);

  logic [WIDTH-1:0] pins_sync;
  logic [WIDTH-1:0] out_q, dir_q, mask_q, cap_q, edge_hit;
  logic             cap_wr;
  logic [WIDTH-1:0] pending;

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pins_sync)
  );

  gpio_out_regs #(.WIDTH(WIDTH)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .out_q  (out_q),
    .dir_q  (dir_q),
    .mask_q (mask_q)
  );

  assign cap_wr = bus_wr && (bus_addr == A_CAPT);

  gpio_edge_cap #(
    .WIDTH     (WIDTH),
    .EDGE_KIND (EDGE_KIND),
    .W1C       (W1C)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  (pins_sync),
    .clr_wr   (cap_wr),
    .clr_data (bus_wdata),
    .edge_hit (edge_hit),
    .cap_q    (cap_q)
  );

  assign pin_oe  = dir_q;
  assign pin_out = out_q & dir_q;
  assign pending = cap_q & mask_q;
  assign irq     = |pending;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_DATA:  bus_rdata = pins_sync;
        A_DIR:   bus_rdata = dir_q;
        A_MASK:  bus_rdata = mask_q;
        A_CAPT:  bus_rdata = cap_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0 && cap_q != '0));

  // R3
  drive_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);

  // R8
  irq_follows_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit & mask_q) != '0 && !bus_wr) |=> irq);

endmodule

// File: tb/gpio_edge_port_bench.sv
module gpio_edge_port_model #(
  parameter int KIND = 0,
  parameter int PER_BIT = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        rd,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic [31:0] pins,
  output logic [31:0] e_out,
  output logic [31:0] e_oe,
  output logic [31:0] e_rdata,
  output logic        e_irq
);
  logic [31:0] hist[$];
  logic [31:0] m_out, m_dir, m_mask, m_cap, m_seen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{32'h0, 32'h0, 32'h0};
      m_out = 0; m_dir = 0; m_mask = 0; m_cap = 0; m_seen = 0;
    end else begin
      logic [31:0] now_v, old_v, ev, wipe;
      now_v = hist[1];
      old_v = hist[2];
      if (KIND == 0)      ev = now_v & ~old_v;
      else if (KIND == 1) ev = old_v & ~now_v;
      else                ev = now_v ^ old_v;
      wipe = 0;
      if (wr && addr == 3) wipe = (PER_BIT != 0) ? wdata : 32'hffff_ffff;
      m_cap = (m_cap & ~wipe) | ev;
      if (wr) begin
        case (addr)
          0: m_out = wdata;
          1: m_dir = wdata;
          2: m_mask = wdata;
          4: m_out = m_out | wdata;
          5: m_out = m_out & ~wdata;
          default: ;
        endcase
      end
      hist.push_front(pins);
      void'(hist.pop_back());
      m_seen = hist[1];
    end
  end

  always_comb begin
    e_out = m_out & m_dir;
    e_oe  = m_dir;
    e_irq = (m_cap & m_mask) != 0;
    e_rdata = 0;
    if (rd) begin
      case (addr)
        0: e_rdata = m_seen;
        1: e_rdata = m_dir;
        2: e_rdata = m_mask;
        3: e_rdata = m_cap;
        default: e_rdata = 0;
      endcase
    end
  end
endmodule

module gpio_edge_port_bench;
  import gpio_edge_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] pin_in = '0;

  int n_checks = 0;
  int n_fails = 0;
  bit compare_on = 1'b0;

  always #10 clk = ~clk;

  logic [31:0] d_rdata[3], d_out[3], d_oe[3], x_rdata[3], x_out[3], x_oe[3];
  logic        d_irq[3], x_irq[3];

  gpio_edge_port u_gpio_edge_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(d_rdata[0]), .pin_in(pin_in),
    .pin_out(d_out[0]), .pin_oe(d_oe[0]), .irq(d_irq[0]));
  gpio_edge_port_model #(.KIND(0), .PER_BIT(1)) u_m0 (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata),
    .pins(pin_in), .e_out(x_out[0]), .e_oe(x_oe[0]), .e_rdata(x_rdata[0]), .e_irq(x_irq[0]));

  gpio_edge_port #(.EDGE_KIND(EDGE_FALL), .W1C(1'b0)) u_fall (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(d_rdata[1]), .pin_in(pin_in),
    .pin_out(d_out[1]), .pin_oe(d_oe[1]), .irq(d_irq[1]));
  gpio_edge_port_model #(.KIND(1), .PER_BIT(0)) u_m1 (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata),
    .pins(pin_in), .e_out(x_out[1]), .e_oe(x_oe[1]), .e_rdata(x_rdata[1]), .e_irq(x_irq[1]));

  gpio_edge_port #(.EDGE_KIND(EDGE_ANY), .W1C(1'b1)) u_any (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(d_rdata[2]), .pin_in(pin_in),
    .pin_out(d_out[2]), .pin_oe(d_oe[2]), .irq(d_irq[2]));
  gpio_edge_port_model #(.KIND(2), .PER_BIT(1)) u_m2 (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata),
    .pins(pin_in), .e_out(x_out[2]), .e_oe(x_oe[2]), .e_rdata(x_rdata[2]), .e_irq(x_irq[2]));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string rd_req(input logic [2:0] a);
    case (a)
      3'd0: rd_req = "R2 data read";
      3'd1: rd_req = "R3 direction read";
      3'd2: rd_req = "R8 mask read";
      3'd3: rd_req = "R6 capture read";
      3'd4, 3'd5: rd_req = "R4 set/clear read";
      default: rd_req = "R9 unused read";
    endcase
  endfunction

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (compare_on) begin
      for (int i = 0; i < 3; i++) begin
        check("R3 pin_out", d_out[i], x_out[i]);
        check("R3 pin_oe", d_oe[i], x_oe[i]);
        check("R8 irq", {31'd0, d_irq[i]}, {31'd0, x_irq[i]});
        check(bus_rd ? rd_req(bus_addr) : "R9 idle read", d_rdata[i], x_rdata[i]);
      end
    end
  end

  // called right after a negedge; holds the strobe through one posedge
  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    #1;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, observed while reset is still held
    peek(3'd1); check("R1 direction zero", d_rdata[0], 32'h0);
    peek(3'd2); check("R1 mask zero", d_rdata[0], 32'h0);
    peek(3'd3); check("R1 capture zero", d_rdata[0], 32'h0);
    check("R1 oe zero", d_oe[0], 32'h0);
    check("R1 irq low", {31'd0, d_irq[0]}, 32'h0);
    bus_rd = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    compare_on = 1'b1;

    // R3 / R4 directed
    bus_write(3'd1, 32'hffff_ffff);
    bus_write(3'd0, 32'h0000_0000);
    bus_write(3'd4, 32'h0000_0040);
    check("R4 set writes bit 6", d_out[0], 32'h0000_0040);
    bus_write(3'd0, 32'h0000_00ff);
    bus_write(3'd5, 32'h0000_0008);
    check("R4 clear removes bit 3", d_out[0], 32'h0000_00f7);
    peek(3'd4); check("R4 set reads zero", d_rdata[0], 32'h0);
    peek(3'd5); check("R4 clear reads zero", d_rdata[0], 32'h0);
    bus_rd = 1'b0;
    bus_write(3'd1, 32'h0000_000f);
    check("R3 drive gated by direction", d_out[0], 32'h0000_0007);
    bus_write(3'd6, 32'hffff_ffff);
    check("R9 write to address 6 ignored", d_oe[0], 32'h0000_000f);

    // R2 / R5 directed: rise on bit 0 before edge k
    bus_write(3'd2, 32'h0000_0001);
    pin_in = 32'h0000_0001;
    @(negedge clk);
    peek(3'd0); check("R2 not yet synchronised", d_rdata[0], 32'h0);
    bus_rd = 1'b0;
    @(negedge clk);
    peek(3'd0); check("R2 data read after two flops", d_rdata[0], 32'h1);
    peek(3'd3); check("R5 capture not yet set", d_rdata[0], 32'h0);
    bus_rd = 1'b0;
    @(negedge clk);
    peek(3'd3); check("R5 rising edge captured", d_rdata[0], 32'h1);
    check("R8 irq raised", {31'd0, d_irq[0]}, 32'h1);
    bus_rd = 1'b0;

    // R7: edge on bit 1 lands in the cycle of a clear of bit 1
    pin_in = 32'h0000_0003;
    @(negedge clk);
    @(negedge clk);
    bus_write(3'd3, 32'h0000_0003);
    peek(3'd3); check("R7 edge beats clear", d_rdata[0], 32'h0000_0002);
    bus_rd = 1'b0;
    check("R8 irq drops with bit 0 cleared", {31'd0, d_irq[0]}, 32'h0);
    // R6 sticky: hold pins, capture stays
    repeat (4) @(negedge clk);
    peek(3'd3); check("R6 capture sticky", d_rdata[0], 32'h0000_0002);
    bus_rd = 1'b0;

    // random traffic, compared every cycle against the models
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 3) pin_in = $urandom();
      else if (op < 5) pin_in = pin_in ^ (32'h1 << $urandom_range(0, 31));
      if (op >= 6) begin
        bus_addr = 3'($urandom_range(0, 7));
        bus_wdata = $urandom();
        bus_wr = 1'b1; bus_rd = 1'b0;
      end else begin
        bus_addr = 3'($urandom_range(0, 7));
        bus_rd = 1'b1; bus_wr = 1'b0;
      end
      @(negedge clk);
    end
    bus_wr = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
    compare_on = 1'b0;
    finish_run();
  end

endmodule